// File: doc/BRIEF.md
# Handshake Line Status Unit

This block watches four asynchronous handshake lines coming from peripherals and turns them into a status byte that software can read. Each line is first brought into the clock domain through a two-stage synchronizer. It is then corrected for its own programmed polarity. An edge detector looks for the line moving from its inactive level to its active level. When that happens, and the line's pair is enabled, a sticky event flag is set. Software clears the flag by writing a 1 to it.

An 8-bit general control register holds three things: a two-bit port mode, which is passed out to the data-path logic; one enable for lines 1 and 2 as a pair and one for lines 3 and 4 as a pair; and one polarity bit per line. The status byte shows the raw synchronized level of each line in its upper half and the sticky flags in its lower half. A level interrupt request is raised when a flag is set on a line whose interrupt enable input is high and whose pair is enabled.

The block has one write port. Address 0 selects the control register and address 1 selects the status register.

Top module: `hsl_status_unit`

## Requirements
- R1: After reset the control register reads 0x00, the four status flags read 0, `port_mode` reads 0 and `irq` is low.
- R2: A write to address 0 loads the control register, which reads back on `ctrl_q` on the next cycle. Its fields are: bits 7:6 port mode (driven on `port_mode`); bit 5 enables lines 3 and 4; bit 4 enables lines 1 and 2; bits 3:0 set the polarity of lines 4, 3, 2 and 1 (1 = active high, 0 = active low). Writing 0x30 gives mode 0, both pairs enabled and all lines active low.
- R3: `status_q[7:4]` shows the raw level of `hs_line[3:0]` (line 4 in bit 7, line 1 in bit 4) two clock edges after the pin changes.
- R4: `status_q[i]` (line i+1) becomes 1 three clock edges after the line moves from its inactive to its active level, as set by the line's polarity bit.
- R5: A move from the active to the inactive level sets no flag.
- R6: A line whose pair-enable bit is 0 never sets its flag.
- R7: A write to address 1 clears each flag whose `wr_data[3:0]` bit is 1. Flags whose data bit is 0 keep their value, and `wr_data[7:4]` has no effect.
- R8: If a flag's set event and its write-one-to-clear fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when some flag i is set with `line_irq_en[i]` high and line i's pair enabled. It stays high until those flags are cleared, even after the lines return to their inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = status register |
| wr_data | input | 8 | Write data |
| hs_line | input | 4 | Asynchronous handshake lines; bit 0 is line 1 |
| line_irq_en | input | 4 | Per-line interrupt enable; bit 0 is line 1 |
| ctrl_q | output | 8 | Control register contents |
| port_mode | output | 2 | Port mode field of the control register |
| status_q | output | 8 | Line levels in bits 7:4, sticky flags in bits 3:0 |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sweeps all 16 polarity settings against all 4 pair-enable settings. For each combination it drives every line inactive, then active, then inactive again. This separates the flags that rising activity sets from those that the polarity bit or the pair enable should block, and it shows that falling activity sets nothing. A different interrupt-enable pattern is used in each pass, so the masking of `irq` is checked against many combinations of set flags. Directed cases cover a partial clear that also writes the upper nibble, a clear that lands in the same cycle as a set event, and the exact cycle in which the level and flag bits first change.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  localparam int unsigned HSL_LINES   = 4;
  localparam int unsigned HSL_PAIRS   = HSL_LINES / 2;
  localparam int unsigned HSL_DATA_W  = 8;
  localparam int unsigned HSL_MODE_LO = HSL_LINES + HSL_PAIRS;

  typedef enum logic {
    HSL_ADDR_CTRL   = 1'b0,
    HSL_ADDR_STATUS = 1'b1
  } hsl_addr_e;

  typedef struct packed {
    logic [1:0]           mode;
    logic [HSL_PAIRS-1:0] pair_en;
    logic [HSL_LINES-1:0] sense;
  } hsl_ctrl_t;
endpackage

// File: rtl/hsl_rst_sync.sv
module hsl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/hsl_flags.sv
module hsl_flags #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] level,
  input  logic [LINES-1:0] sense,
  input  logic [LINES-1:0] line_en,
  input  logic [LINES-1:0] clr_req,
  output logic [LINES-1:0] flags_q
);
  logic [LINES-1:0] act;
  logic [LINES-1:0] prev_act_q;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] flags_d;

  // polarity correction: a sense bit of 1 means the high level is active
  always_comb begin
    act     = ~(level ^ sense);
    rise    = act & ~prev_act_q & line_en;
    flags_d = (flags_q & ~clr_req) | rise;   // a set event beats a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act_q <= '0;
      flags_q    <= '0;
    end else begin
      prev_act_q <= act;
      flags_q    <= flags_d;
    end
  end

  p_flag_only_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q)) & ~$past(act & ~prev_act_q)) == '0);

  p_pair_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q)) & ~$past(line_en)) == '0);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & $past(clr_req & ~rise)) == '0);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & $past(rise)) == $past(rise));
endmodule

// File: rtl/hsl_status_unit.sv
module hsl_status_unit
  import hsl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [HSL_DATA_W-1:0] wr_data,
  input  logic [HSL_LINES-1:0]  hs_line,
  input  logic [HSL_LINES-1:0]  line_irq_en,
  output logic [HSL_DATA_W-1:0] ctrl_q,
  output logic [1:0]            port_mode,
  output logic [HSL_DATA_W-1:0] status_q,
  output logic                  irq
);
  logic                 rst_sync_n;
  hsl_ctrl_t            ctrl_r;
  hsl_ctrl_t            ctrl_d;
  logic                 ctrl_we;
  logic [HSL_LINES-1:0] clr_req;
  logic [HSL_LINES-1:0] level;
  logic [HSL_LINES-1:0] line_en;
  logic [HSL_LINES-1:0] flags;

  hsl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // write decode
  always_comb begin
    ctrl_we = wr_en && (wr_addr == HSL_ADDR_CTRL);
    clr_req = (wr_en && (wr_addr == HSL_ADDR_STATUS)) ? wr_data[HSL_LINES-1:0] : '0;
    ctrl_d  = ctrl_r;
    if (ctrl_we) ctrl_d = hsl_ctrl_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_r <= '0;
    else             ctrl_r <= ctrl_d;
  end

  // one pair-enable bit covers two neighbouring lines
  generate
    for (genvar i = 0; i < HSL_LINES; i++) begin : g_pair
      assign line_en[i] = ctrl_r.pair_en[i/2];
    end
  endgenerate

  hsl_sync #(.WIDTH(HSL_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_in(hs_line), .sync_out(level));

  hsl_flags #(.LINES(HSL_LINES)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .level(level), .sense(ctrl_r.sense),
    .line_en(line_en), .clr_req(clr_req), .flags_q(flags));

  assign ctrl_q    = ctrl_r;
  assign port_mode = ctrl_r.mode;
  assign status_q  = {level, flags};
  assign irq       = |(flags & line_irq_en & line_en);

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == HSL_ADDR_CTRL) |=> ctrl_q == $past(wr_data));

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && wr_addr == HSL_ADDR_CTRL) |=> $stable(ctrl_q));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (status_q[HSL_LINES-1:0] != '0));
endmodule

// File: tb/hsl_status_unit_test.sv
module hsl_status_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       wr_addr;
  logic [7:0] wr_data;
  logic [3:0] hs_line;
  logic [3:0] line_irq_en;
  logic [7:0] ctrl_q;
  logic [1:0] port_mode;
  logic [7:0] status_q;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hsl_status_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hs_line(hs_line), .line_irq_en(line_irq_en),
    .ctrl_q(ctrl_q), .port_mode(port_mode), .status_q(status_q), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_flags;
    logic [3:0] ie;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    hs_line = 4'h0; line_irq_en = 4'h0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    // R1 reset state
    check("R1 ctrl", ctrl_q, 8'h00);
    check("R1 flags", {4'h0, status_q[3:0]}, 8'h00);
    check("R1 mode", {6'h0, port_mode}, 8'h00);
    check("R1 irq", {7'h0, irq}, 8'h00);

    // R2 mode field and the 0x30 setting
    reg_write(1'b0, 8'hC5);
    check("R2 ctrl readback", ctrl_q, 8'hC5);
    check("R2 mode", {6'h0, port_mode}, 8'h03);
    reg_write(1'b0, 8'h30);
    check("R2 ctrl 0x30", ctrl_q, 8'h30);
    check("R2 mode 0x30", {6'h0, port_mode}, 8'h00);

    // R3 level latency: visible after two edges, not after one
    hs_line = 4'h0; wait_neg(4); reg_write(1'b1, 8'h0F);
    hs_line = 4'hA;
    wait_neg(1);
    check("R3 one edge", {4'h0, status_q[7:4]}, 8'h00);
    wait_neg(1);
    check("R3 two edges", {4'h0, status_q[7:4]}, 8'h0A);
    hs_line = 4'hF; wait_neg(4); reg_write(1'b1, 8'h0F);

    // R4 flag latency for active-low lines going low
    hs_line = 4'h0;
    wait_neg(2);
    check("R4 before third edge", {4'h0, status_q[3:0]}, 8'h00);
    wait_neg(1);
    check("R4 third edge", {4'h0, status_q[3:0]}, 8'h0F);

    // R7 partial clear, upper data bits ignored
    reg_write(1'b1, 8'hF1);
    check("R7 partial clear", status_q, 8'h0E);
    reg_write(1'b1, 8'h0E);
    check("R7 full clear", status_q, 8'h00);

    // R8 set event and clear in the same cycle
    hs_line = 4'hF; wait_neg(4); reg_write(1'b1, 8'h0F);
    check("R8 pre", {4'h0, status_q[3:0]}, 8'h00);
    hs_line = 4'hE;                  // line 1 goes active (low)
    wait_neg(2);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h0F;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 set wins", {4'h0, status_q[3:0]}, 8'h01);
    reg_write(1'b1, 8'h0F);
    check("R8 later clear", {4'h0, status_q[3:0]}, 8'h00);

    // sweep: every polarity against every pair-enable setting
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 4; p++) begin
        ie = 4'(s * 3 + p * 5 + 1);
        line_irq_en = ie;
        reg_write(1'b0, {2'b00, 2'(p), 4'(s)});
        hs_line = ~4'(s);
        wait_neg(4);
        reg_write(1'b1, 8'h0F);
        wait_neg(1);
        check("R7 sweep clear", {4'h0, status_q[3:0]}, 8'h00);
        check("R3 sweep level", {4'h0, status_q[7:4]}, {4'h0, ~4'(s)});
        hs_line = 4'(s);
        wait_neg(3);
        exp_flags = {p[1], p[1], p[0], p[0]};
        check("R4 R6 sweep set", {4'h0, status_q[3:0]}, {4'h0, exp_flags});
        check("R9 sweep irq", {7'h0, irq}, {7'h0, |(exp_flags & ie)});
        reg_write(1'b1, 8'h0F);
        hs_line = ~4'(s);
        wait_neg(4);
        check("R5 sweep release", {4'h0, status_q[3:0]}, 8'h00);
        check("R9 sweep irq low", {7'h0, irq}, 8'h00);
      end
    end

    // R9 level hold after lines go inactive, then drop on clear
    line_irq_en = 4'h4;
    reg_write(1'b0, 8'h30);
    hs_line = 4'hF; wait_neg(4); reg_write(1'b1, 8'h0F);
    hs_line = 4'hB; wait_neg(3);
    hs_line = 4'hF; wait_neg(4);
    check("R9 irq held", {7'h0, irq}, 8'h01);
    reg_write(1'b1, 8'h04);
    check("R9 irq cleared", {7'h0, irq}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule